// File: doc/BRIEF.md
# I2C Master Register and FIFO Front End

This block is the memory-mapped side of an I2C master. Software programs a byte count, a 7-bit target address and the bus timing words, loads or unloads a 16-entry byte FIFO that serves both directions, and launches a transfer from the control word. The block then hands bytes one at a time to a separate bit-level engine over a small request and acknowledge handshake. It counts bytes down, flags completion, acknowledge errors and stretch timeouts, and raises one interrupt line. Waveform generation on the bus wires belongs to the engine.

The handshake is a single-outstanding protocol. `eng_req` pulses for one cycle with the byte to send on `eng_wbyte`, or with `eng_read` high to ask for a byte. The engine answers later with a one-cycle `eng_ack`, carrying `eng_rbyte` and `eng_nack`. `eng_start` marks each new frame, and `eng_rep` says whether the frame opens with a repeated start. `eng_abort` tells the engine to send NACK and STOP.

Top module: `i2cm_regfront`

## Requirements
- R1: After reset the transfer-active flag is 0, the interrupt is low, FIFO reads return 0, and the status word reads 0x054.
- R2: The words at 0x08 (length, 16 bits), 0x0C (target, 7 bits), 0x14 (divider, 16 bits), 0x18 (delays, 32 bits) and 0x1C (stretch timeout, 16 bits) read back what was written, truncated to their width. Control at 0x00 reads back bits 0, 8, 9, 10 and 15.
- R3: A write to 0x10 appends its low byte to the FIFO, and a read of 0x10 removes and returns the oldest byte. A write to a full FIFO is ignored. A read of an empty FIFO returns 0.
- R4: Status at 0x04 gives the FIFO state. Bit 2 is set when the FIFO holds fewer than 4 bytes, bit 3 when it holds more than 12, bit 4 when it is not full, bit 5 when it is not empty, bit 6 when it is empty, and bit 7 when it is full.
- R5: A control write with bit 7 and bit 15 both set loads the length into the byte counter, sets status bit 0, and pulses `eng_start`. If bit 15 is clear, the start does nothing. Bit 0 of the same write selects a read.
- R6: In a write transfer, each request pops one FIFO byte onto `eng_wbyte`. Once the counted bytes are acknowledged, status bit 0 clears and status bit 1 (done) sets.
- R7: In a read transfer, each acknowledged byte `eng_rbyte` is pushed into the FIFO in arrival order.
- R8: Writing 1 to status bit 1, 8 or 9 clears that bit. Writing 0 leaves it unchanged.
- R9: An acknowledge carrying `eng_nack` sets status bit 8 and ends the transfer without setting done.
- R10: A pulse on `eng_tmo` sets status bit 9 and ends any transfer.
- R11: A control write with bit 4 or bit 5 set empties the FIFO. If a read is active at that moment, `eng_abort` pulses, the transfer ends without done, and any acknowledge that arrives later is discarded.
- R12: A start accepted while a write transfer is active pulses `eng_start` with `eng_rep` high. Any other start has `eng_rep` low.
- R13: `irq` is the OR of five terms: done AND control bit 8; status bit 2 AND control bit 9 AND an active write; status bit 3 AND control bit 10 AND an active read; status bit 8; and status bit 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the FIFO at 0x10) |
| bus_addr | input | 5 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| irq | output | 1 | Interrupt request |
| eng_start | output | 1 | New frame pulse |
| eng_rep | output | 1 | Frame begins with a repeated start |
| eng_read | output | 1 | Current transfer direction is read |
| eng_tgt | output | 7 | Target address |
| eng_req | output | 1 | Byte work request pulse |
| eng_wbyte | output | 8 | Byte to transmit |
| eng_ack | input | 1 | Byte finished |
| eng_nack | input | 1 | Target did not acknowledge |
| eng_rbyte | input | 8 | Received byte |
| eng_tmo | input | 1 | Clock-stretch timeout pulse |
| eng_abort | output | 1 | Send NACK and STOP now |
| cfg_div | output | 16 | Clock divider |
| cfg_del | output | 32 | Edge delays |
| cfg_clkt | output | 16 | Stretch timeout limit |

## Verification
The case that matters most is a start command landing while a write frame is still active. In that same cycle the start logic reloads the counter and the byte-issue logic is deciding whether to send work to the engine. The bench opens a write with an empty FIFO, so the frame stays active with no request outstanding. It then issues a read start in that state. The result passes if `eng_rep` is high for that start, and if exactly the newly counted bytes later arrive in the FIFO in the order the engine model produced them.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  // word index of each register (byte address bits 4:2)
  localparam logic [2:0] W_CTRL = 3'd0;
  localparam logic [2:0] W_STAT = 3'd1;
  localparam logic [2:0] W_LEN  = 3'd2;
  localparam logic [2:0] W_TGT  = 3'd3;
  localparam logic [2:0] W_FIFO = 3'd4;
  localparam logic [2:0] W_DIV  = 3'd5;
  localparam logic [2:0] W_DEL  = 3'd6;
  localparam logic [2:0] W_CLKT = 3'd7;

  // control bit positions
  localparam int C_RD   = 0;
  localparam int C_CLRA = 4;
  localparam int C_CLRB = 5;
  localparam int C_GO   = 7;
  localparam int C_IED  = 8;
  localparam int C_IET  = 9;
  localparam int C_IER  = 10;
  localparam int C_EN   = 15;

  // status bits cleared by writing one
  localparam int S_DONE = 1;
  localparam int S_NAK  = 8;
  localparam int S_TMO  = 9;

  typedef struct packed {
    logic en;
    logic ier;
    logic iet;
    logic ied;
    logic rd;
  } ctrl_t;
endpackage

// File: rtl/i2cm_fifo.sv
module i2cm_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  pdata,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          full
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp_q, rp_q, wp_d, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          push_ok, pop_ok;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign push_ok = push && !full && !flush;
  assign pop_ok  = pop && !empty && !flush;
  assign head    = empty ? '0 : mem[rp_q];
  assign count   = cnt_q;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (flush) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
    end else begin
      if (push_ok) wp_d = (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      if (pop_ok)  rp_d = (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      cnt_d = cnt_q + CW'(push_ok) - CW'(pop_ok);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp_q] <= pdata;
  end

  // R3
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  // R3
  fifo_full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !flush) |=> full);
endmodule

// File: rtl/i2cm_xfer.sv
module i2cm_xfer #(
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          start_rd,
  input  logic          clr,
  input  logic [LW-1:0] dlen,
  input  logic          w1c_done,
  input  logic          w1c_nak,
  input  logic          w1c_tmo,
  input  logic          fifo_empty,
  input  logic          fifo_full,
  input  logic [7:0]    fifo_head,
  input  logic          eng_ack,
  input  logic          eng_nack,
  input  logic [7:0]    eng_rbyte,
  input  logic          eng_tmo,
  output logic          active,
  output logic          dir_rd,
  output logic          done,
  output logic          nak,
  output logic          tmo,
  output logic          eng_req,
  output logic [7:0]    eng_wbyte,
  output logic          eng_start,
  output logic          eng_rep,
  output logic          eng_abort,
  output logic          fifo_pop,
  output logic          fifo_push,
  output logic [7:0]    fifo_pdata
);
  logic          act_q, act_d, dir_q, dir_d, pend_q, pend_d;
  logic          done_q, done_d, nak_q, nak_d, tmo_q, tmo_d;
  logic [LW-1:0] cnt_q, cnt_d;

  always_comb begin
    act_d      = act_q;
    dir_d      = dir_q;
    pend_d     = pend_q;
    cnt_d      = cnt_q;
    done_d     = done_q & ~w1c_done;
    nak_d      = nak_q & ~w1c_nak;
    tmo_d      = tmo_q & ~w1c_tmo;
    eng_req    = 1'b0;
    eng_wbyte  = 8'd0;
    eng_start  = 1'b0;
    eng_rep    = 1'b0;
    eng_abort  = 1'b0;
    fifo_pop   = 1'b0;
    fifo_push  = 1'b0;
    fifo_pdata = eng_rbyte;
    // engine finished one byte; late answers after an abort are dropped
    if (eng_ack) begin
      pend_d = 1'b0;
      if (act_q && cnt_q != '0) begin
        cnt_d = cnt_q - 1'b1;
        if (dir_q) fifo_push = 1'b1;
        if (eng_nack) begin
          nak_d = 1'b1;
          act_d = 1'b0;
        end
      end
    end
    if (eng_tmo) begin
      tmo_d  = 1'b1;
      act_d  = 1'b0;
      pend_d = 1'b0;
    end
    // hand out the next byte
    if (act_q && !pend_q && cnt_q != '0 && !eng_tmo) begin
      if (!dir_q && !fifo_empty) begin
        eng_req   = 1'b1;
        eng_wbyte = fifo_head;
        fifo_pop  = 1'b1;
        pend_d    = 1'b1;
      end else if (dir_q && !fifo_full) begin
        eng_req = 1'b1;
        pend_d  = 1'b1;
      end
    end
    if (act_q && cnt_q == '0 && !pend_q && !eng_tmo) begin
      act_d  = 1'b0;
      done_d = 1'b1;
    end
    if (clr && act_q && dir_q) begin
      eng_abort = 1'b1;
      act_d     = 1'b0;
    end
    if (start) begin
      eng_start = 1'b1;
      eng_rep   = act_q && !dir_q;
      act_d     = 1'b1;
      dir_d     = start_rd;
      cnt_d     = dlen;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      dir_q  <= 1'b0;
      pend_q <= 1'b0;
      cnt_q  <= '0;
      done_q <= 1'b0;
      nak_q  <= 1'b0;
      tmo_q  <= 1'b0;
    end else begin
      act_q  <= act_d;
      dir_q  <= dir_d;
      pend_q <= pend_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
      nak_q  <= nak_d;
      tmo_q  <= tmo_d;
    end
  end

  assign active = act_q;
  assign dir_rd = dir_q;
  assign done   = done_q;
  assign nak    = nak_q;
  assign tmo    = tmo_q;

  // R6
  req_when_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req |-> act_q);
  // R6
  single_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req |=> !eng_req);
  // R6
  done_after_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(act_q));
  // R11
  abort_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_abort && !eng_start) |=> !act_q);
endmodule

// File: rtl/i2cm_regfront.sv
module i2cm_regfront
  import i2cm_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LW    = 16,
  parameter int TW    = 7,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [4:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq,
  output logic        eng_start,
  output logic        eng_rep,
  output logic        eng_read,
  output logic [6:0]  eng_tgt,
  output logic        eng_req,
  output logic [7:0]  eng_wbyte,
  input  logic        eng_ack,
  input  logic        eng_nack,
  input  logic [7:0]  eng_rbyte,
  input  logic        eng_tmo,
  output logic        eng_abort,
  output logic [15:0] cfg_div,
  output logic [31:0] cfg_del,
  output logic [15:0] cfg_clkt
);
  localparam logic [CW-1:0] LOW_MARK  = CW'(DEPTH / 4);
  localparam logic [CW-1:0] HIGH_MARK = CW'((3 * DEPTH) / 4);

  logic [2:0]    widx;
  logic          we_ctrl, we_stat, we_len, we_tgt, we_fifo, we_div, we_del, we_clkt;
  logic          go, clr, host_pop;
  ctrl_t         ctrl_q;
  logic [LW-1:0] len_q;
  logic [TW-1:0] tgt_q;
  logic [15:0]   div_q, clkt_q;
  logic [31:0]   del_q;

  logic          f_push, f_pop, f_empty, f_full, x_push, x_pop;
  logic [7:0]    f_pdata, f_head, x_pdata;
  logic [CW-1:0] f_count;
  logic          act, dir, done, nak, tmo, txw, rxr;
  logic [31:0]   stat_v;

  assign widx     = bus_addr[4:2];
  assign we_ctrl  = bus_wr && widx == W_CTRL;
  assign we_stat  = bus_wr && widx == W_STAT;
  assign we_len   = bus_wr && widx == W_LEN;
  assign we_tgt   = bus_wr && widx == W_TGT;
  assign we_fifo  = bus_wr && widx == W_FIFO;
  assign we_div   = bus_wr && widx == W_DIV;
  assign we_del   = bus_wr && widx == W_DEL;
  assign we_clkt  = bus_wr && widx == W_CLKT;
  assign go       = we_ctrl && bus_wdata[C_GO] && bus_wdata[C_EN];
  assign clr      = we_ctrl && (bus_wdata[C_CLRA] || bus_wdata[C_CLRB]);
  assign host_pop = bus_rd && widx == W_FIFO;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      len_q  <= '0;
      tgt_q  <= '0;
      div_q  <= '0;
      del_q  <= '0;
      clkt_q <= '0;
    end else begin
      if (we_ctrl) ctrl_q <= '{en: bus_wdata[C_EN], ier: bus_wdata[C_IER],
                               iet: bus_wdata[C_IET], ied: bus_wdata[C_IED],
                               rd: bus_wdata[C_RD]};
      if (we_len)  len_q  <= bus_wdata[LW-1:0];
      if (we_tgt)  tgt_q  <= bus_wdata[TW-1:0];
      if (we_div)  div_q  <= bus_wdata[15:0];
      if (we_del)  del_q  <= bus_wdata;
      if (we_clkt) clkt_q <= bus_wdata[15:0];
    end
  end

  // the engine side owns the FIFO ports when it needs them
  assign f_push  = x_push || we_fifo;
  assign f_pdata = x_push ? x_pdata : bus_wdata[7:0];
  assign f_pop   = x_pop || host_pop;

  i2cm_fifo #(.W(8), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(clr), .push(f_push), .pdata(f_pdata),
    .pop(f_pop), .head(f_head), .count(f_count), .empty(f_empty), .full(f_full)
  );

  i2cm_xfer #(.LW(LW)) u_xfer (
    .clk(clk), .rst_n(rst_n), .start(go), .start_rd(bus_wdata[C_RD]), .clr(clr),
    .dlen(len_q), .w1c_done(we_stat && bus_wdata[S_DONE]),
    .w1c_nak(we_stat && bus_wdata[S_NAK]), .w1c_tmo(we_stat && bus_wdata[S_TMO]),
    .fifo_empty(f_empty), .fifo_full(f_full), .fifo_head(f_head),
    .eng_ack(eng_ack), .eng_nack(eng_nack), .eng_rbyte(eng_rbyte), .eng_tmo(eng_tmo),
    .active(act), .dir_rd(dir), .done(done), .nak(nak), .tmo(tmo),
    .eng_req(eng_req), .eng_wbyte(eng_wbyte), .eng_start(eng_start),
    .eng_rep(eng_rep), .eng_abort(eng_abort), .fifo_pop(x_pop),
    .fifo_push(x_push), .fifo_pdata(x_pdata)
  );

  assign txw    = f_count < LOW_MARK;
  assign rxr    = f_count > HIGH_MARK;
  assign stat_v = {22'd0, tmo, nak, f_full, f_empty, !f_empty, !f_full,
                   rxr, txw, done, act};

  always_comb begin
    unique case (widx)
      W_CTRL:  bus_rdata = {16'd0, ctrl_q.en, 4'd0, ctrl_q.ier, ctrl_q.iet,
                            ctrl_q.ied, 7'd0, ctrl_q.rd};
      W_STAT:  bus_rdata = stat_v;
      W_LEN:   bus_rdata = 32'(len_q);
      W_TGT:   bus_rdata = 32'(tgt_q);
      W_FIFO:  bus_rdata = {24'd0, f_head};
      W_DIV:   bus_rdata = {16'd0, div_q};
      W_DEL:   bus_rdata = del_q;
      default: bus_rdata = {16'd0, clkt_q};
    endcase
  end

  assign irq = (done && ctrl_q.ied) || (txw && ctrl_q.iet && act && !dir) ||
               (rxr && ctrl_q.ier && act && dir) || nak || tmo;

  assign eng_read = dir;
  assign eng_tgt  = 7'(tgt_q);
  assign cfg_div  = div_q;
  assign cfg_del  = del_q;
  assign cfg_clkt = clkt_q;

  // R13
  fault_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nak || tmo) |-> irq);
  // R10
  tmo_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_tmo |=> (tmo && !act));
  // R5
  start_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> act);
endmodule

// File: tb/i2cm_regfront_tb.sv
module i2cm_regfront_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, eng_start, eng_rep, eng_read, eng_req, eng_abort;
  logic [6:0]  eng_tgt;
  logic [7:0]  eng_wbyte;
  logic        eng_ack, eng_nack, eng_tmo = 1'b0;
  logic [7:0]  eng_rbyte;
  logic [15:0] cfg_div, cfg_clkt;
  logic [31:0] cfg_del;
  logic        inj_nack = 1'b0;

  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  i2cm_regfront u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .eng_start(eng_start),
    .eng_rep(eng_rep), .eng_read(eng_read), .eng_tgt(eng_tgt), .eng_req(eng_req),
    .eng_wbyte(eng_wbyte), .eng_ack(eng_ack), .eng_nack(eng_nack),
    .eng_rbyte(eng_rbyte), .eng_tmo(eng_tmo), .eng_abort(eng_abort),
    .cfg_div(cfg_div), .cfg_del(cfg_del), .cfg_clkt(cfg_clkt)
  );

  // engine model: answers each request three cycles later
  logic [2:0] dly;
  logic [7:0] rd_seed;
  logic [7:0] cap [16];
  int         ncap, nstart;
  logic       last_rep, saw_abort;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly <= '0; rd_seed <= 8'hA0; ncap <= 0; nstart <= 0;
      last_rep <= 1'b0; saw_abort <= 1'b0;
      eng_ack <= 1'b0; eng_nack <= 1'b0; eng_rbyte <= '0;
    end else begin
      eng_ack  <= 1'b0;
      eng_nack <= 1'b0;
      if (eng_start) begin nstart <= nstart + 1; last_rep <= eng_rep; end
      if (eng_abort) saw_abort <= 1'b1;
      if (eng_req) begin
        dly <= 3'd3;
        if (!eng_read && ncap < 16) begin cap[ncap] <= eng_wbyte; ncap <= ncap + 1; end
      end else if (dly != 0) begin
        dly <= dly - 1'b1;
        if (dly == 3'd1) begin
          eng_ack   <= 1'b1;
          eng_nack  <= inj_nack;
          eng_rbyte <= rd_seed;
          rd_seed   <= rd_seed + 1'b1;
        end
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a; #1 v = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic wait_bit(input int b, input string req);
    logic [31:0] v;
    for (int i = 0; i < 300; i++) begin
      rd(5'h04, v);
      if (v[b]) return;
    end
    check(req, 32'(v[b]), 32'd1);
  endtask

  // {address, write value, expected read}
  localparam logic [68:0] VEC [7] = '{
    {5'h08, 32'h0001_2345, 32'h0000_2345},
    {5'h0C, 32'h0000_01FF, 32'h0000_007F},
    {5'h14, 32'h0000_FFFF, 32'h0000_FFFF},
    {5'h18, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
    {5'h1C, 32'h0001_0040, 32'h0000_0040},
    {5'h00, 32'h0000_0701, 32'h0000_0701},
    {5'h00, 32'h0000_0000, 32'h0000_0000}
  };

  initial begin
    #(200000 * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [7:0]  snap;
    int          ns;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(5'h04, v); check("R1 status", v, 32'h054);
    check("R1 irq", 32'(irq), 32'd0);
    rd(5'h10, v); check("R1 R3 empty read", v, 32'd0);

    // R2 register table
    foreach (VEC[i]) begin
      wr(VEC[i][68:64], VEC[i][63:32]);
      rd(VEC[i][68:64], v);
      check("R2 readback", v, VEC[i][31:0]);
    end
    check("R2 cfg_div", 32'(cfg_div), 32'h0000FFFF);

    // R3/R4 FIFO fill and drain
    for (int i = 0; i < 3; i++) wr(5'h10, 32'h100 + 32'(i));
    rd(5'h04, v); check("R4 three bytes", v, 32'h034);
    wr(5'h10, 32'd3);
    rd(5'h04, v); check("R4 four bytes", v, 32'h030);
    for (int i = 4; i < 16; i++) wr(5'h10, 32'(i));
    wr(5'h10, 32'hEE);
    rd(5'h04, v); check("R4 full", v, 32'h0A8);
    for (int i = 0; i < 16; i++) begin
      rd(5'h10, v); check("R3 order", v, 32'(i));
    end
    rd(5'h10, v); check("R3 read when empty", v, 32'd0);

    // R5 start without enable
    ns = nstart;
    wr(5'h08, 32'd2);
    wr(5'h00, 32'h0080);
    rd(5'h04, v); check("R5 disabled start", v, 32'h054);
    check("R5 no engine start", 32'(nstart), 32'(ns));

    // R6 write transfer
    wr(5'h10, 32'h11); wr(5'h10, 32'h22); wr(5'h10, 32'h33);
    wr(5'h08, 32'd3);
    wr(5'h00, 32'h8180);
    wait_bit(1, "R6 done");
    rd(5'h04, v); check("R6 end status", v, 32'h056);
    check("R6 byte count", 32'(ncap), 32'd3);
    check("R6 byte0", 32'(cap[0]), 32'h11);
    check("R6 byte2", 32'(cap[2]), 32'h33);
    check("R13 done irq", 32'(irq), 32'd1);
    wr(5'h04, 32'h0);
    rd(5'h04, v); check("R8 zero keeps done", 32'(v[1]), 32'd1);
    wr(5'h04, 32'h2);
    rd(5'h04, v); check("R8 done cleared", 32'(v[1]), 32'd0);
    check("R13 irq low", 32'(irq), 32'd0);

    // R12 repeated start: write frame with empty FIFO, then read start
    wr(5'h08, 32'd2);
    wr(5'h00, 32'h8280);
    rd(5'h04, v); check("R5 active", 32'(v[0]), 32'd1);
    check("R12 first start", 32'(last_rep), 32'd0);
    check("R13 txw irq", 32'(irq), 32'd1);
    snap = rd_seed;
    wr(5'h00, 32'h8481);
    check("R12 repeated", 32'(last_rep), 32'd1);
    wait_bit(1, "R7 done");
    check("R13 no irq", 32'(irq), 32'd0);
    rd(5'h10, v); check("R7 byte0", v, 32'(snap));
    rd(5'h10, v); check("R7 byte1", v, 32'(snap + 8'd1));
    wr(5'h04, 32'h2);

    // R9 nack
    wr(5'h10, 32'h5A); wr(5'h10, 32'h5B);
    wr(5'h08, 32'd2);
    @(negedge clk); inj_nack = 1'b1;
    wr(5'h00, 32'h8080);
    wait_bit(8, "R9 nack");
    inj_nack = 1'b0;
    rd(5'h04, v); check("R9 ended", v & 32'h103, 32'h100);
    check("R13 nack irq", 32'(irq), 32'd1);
    wr(5'h04, 32'h100);
    rd(5'h04, v); check("R8 nack cleared", 32'(v[8]), 32'd0);
    wr(5'h00, 32'h0010);
    rd(5'h04, v); check("R11 flush", v, 32'h054);

    // R10 timeout
    @(negedge clk); eng_tmo = 1'b1;
    @(negedge clk); eng_tmo = 1'b0;
    rd(5'h04, v); check("R10 timeout", v, 32'h254);
    check("R13 tmo irq", 32'(irq), 32'd1);
    wr(5'h04, 32'h200);
    rd(5'h04, v); check("R8 tmo cleared", v, 32'h054);

    // R11 abort of an active read
    wr(5'h08, 32'd5);
    wr(5'h00, 32'h8081);
    repeat (2) @(negedge clk);
    wr(5'h00, 32'h8010);
    check("R11 abort pulse", 32'(saw_abort), 32'd1);
    repeat (8) @(negedge clk);
    rd(5'h04, v); check("R11 after abort", v, 32'h054);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule